// File: doc/BRIEF.md
# Fast-Clock ADC Sample Packer

This block sits right behind a parallel ADC data bus that delivers one sample on every fast clock. It gathers a run of consecutive samples into one wide word, so that a buffer memory on a slower clock can take them in. Each ADC bit lane feeds its own shift register. When a full group has been shifted in, the lane registers are read out together as one packed word. The oldest sample of the group lands in the lowest slot.

The number of samples loaded so far is counted by a short maximal-length linear feedback shift register (LFSR), not by a binary counter. Because of this, no carry chain runs at the fast rate. The terminal state is worked out at elaboration from the seed and the group size. When the terminal state is reached, the counter goes back to its seed, the word is copied into a holding register and a toggle flag flips. The slow side passes the toggle through two flops and detects the edge. For each toggle it writes the word into an output register and raises a write enable for one cycle.

The block also drives the ADC sample clock as the inverse of its own fast clock, so the converter updates on the falling edge. An edge-select input sets where data is captured: on the rising edge, or on the falling edge and then retimed to the rising edge. The falling-edge setting covers boards whose line delay moves the data eye. The fast-side control is a two-state machine. Reset enters ST_WARM. The transition warm_done moves ST_WARM to ST_PACK after one cycle, while the first real sample settles in the capture register. ST_PACK then stays in place (pack_hold) until reset.

Top module: `adc_sample_packer`

## Requirements
- R1: In every write, slot s of `wr_data_o` (bits s*ADC_WIDTH and up) holds the sample captured s cycles after the sample in slot 0. Slot 0 is the oldest, so the slots form consecutive ramp values.
- R2: Successive writes have no gaps and no repeats. Slot 0 of a write is the sample that follows the last slot of the previous write, as long as no reset comes between them.
- R3: `adc_clk_o` is always the inverse of `clk_fast`: low while `clk_fast` is high, and high while `clk_fast` is low.
- R4: The sample counter is an LFSR. It never holds the all-zero state. On the cycle after its terminal state is counted in ST_PACK, it holds the seed value 1. SAMPLES_PER_WORD must not exceed 2^LFSR_WIDTH-1.
- R5: Exactly one packed word is produced for every SAMPLES_PER_WORD fast cycles in ST_PACK. Successive write enables are therefore SAMPLES_PER_WORD fast periods apart.
- R6: Synchronous active-high resets clear the lane registers, reseed the counter, clear the toggle, and hold `wr_en_o` and `wr_data_o` at 0. The first write after reset release comes no earlier than SAMPLES_PER_WORD fast periods after release.
- R7: `wr_en_o` is high for exactly one slow cycle per word, and `wr_data_o` changes only in a cycle where `wr_en_o` is high.
- R8: With `edge_sel`=0, data is captured on the rising edge of `clk_fast`. With `edge_sel`=1, it is captured on the falling edge and retimed to the rising edge. Both settings meet R1 and R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Sample-rate capture clock |
| rst_fast | input | 1 | Synchronous active-high reset, fast domain |
| clk_slow | input | 1 | Buffer-memory clock |
| rst_slow | input | 1 | Synchronous active-high reset, slow domain |
| edge_sel | input | 1 | 0: rising-edge capture, 1: falling-edge capture then retime |
| adc_data_i | input | ADC_WIDTH | Parallel ADC sample bus |
| adc_clk_o | output | 1 | Sample clock sent to the ADC (inverse of clk_fast) |
| wr_en_o | output | 1 | One-cycle write enable for the buffer memory |
| wr_data_o | output | SAMPLES_PER_WORD*ADC_WIDTH | Packed word, oldest sample in the low slot |

## Verification
The assertions assume that `edge_sel` changes only while `rst_fast` is high. They also assume that the slow clock runs fast enough to sample every toggle level at least twice, and to read the holding register before the next word replaces it. The stimulus keeps within both limits. It changes the edge setting only inside a reset. Its slow clock is half the fast rate with eight samples per word, so a word stays stable for four slow cycles. The ADC model moves to the next ramp value one nanosecond after each rising edge of `adc_clk_o`, which gives the rising-edge capture setup margin and gives the falling-edge path a stable sample.

// File: rtl/adcpk_pkg.sv
package adcpk_pkg;

    typedef enum logic {
        ST_WARM = 1'b0,
        ST_PACK = 1'b1
    } pack_state_e;

    // Feedback taps for a maximal-length Fibonacci LFSR, shifting towards the MSB.
    function automatic logic [15:0] lfsr_taps(input int w);
        case (w)
            3:       return 16'h0006;
            4:       return 16'h000C;
            5:       return 16'h0014;
            6:       return 16'h0030;
            7:       return 16'h0060;
            8:       return 16'h00B8;
            default: return 16'h000C;
        endcase
    endfunction

    function automatic logic [15:0] lfsr_step(input logic [15:0] s, input int w);
        logic        fb;
        logic [15:0] mask;
        fb   = ^(s & lfsr_taps(w));
        mask = (16'd1 << w) - 16'd1;
        return ((s << 1) | {15'd0, fb}) & mask;
    endfunction

    function automatic logic [15:0] lfsr_after(input logic [15:0] seed, input int w, input int n);
        logic [15:0] s;
        s = seed;
        for (int i = 0; i < n; i++) begin
            s = lfsr_step(s, w);
        end
        return s;
    endfunction

endpackage

// File: rtl/adcpk_capture.sv
module adcpk_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          edge_sel,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] fall_q;
    logic [DW-1:0] cap_q;

    always_ff @(negedge clk) begin
        if (rst) fall_q <= '0;
        else     fall_q <= din;
    end

    always_ff @(posedge clk) begin
        if (rst)           cap_q <= '0;
        else if (edge_sel) cap_q <= fall_q;
        else               cap_q <= din;
    end

    assign dout = cap_q;
endmodule

// File: rtl/adcpk_lfsr_count.sv
module adcpk_lfsr_count #(
    parameter int W   = 4,
    parameter int SPW = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         advance,
    output logic [W-1:0] state_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] SEED = W'(1);
    localparam logic [W-1:0] TERM = W'(adcpk_pkg::lfsr_after(16'd1, W, SPW - 1));

    logic [W-1:0] lfsr_q;
    logic [W-1:0] lfsr_nxt;

    assign lfsr_nxt = W'(adcpk_pkg::lfsr_step(16'(lfsr_q), W));
    assign wrap_o   = advance && (lfsr_q == TERM);

    always_ff @(posedge clk) begin
        if (rst)          lfsr_q <= SEED;
        else if (wrap_o)  lfsr_q <= SEED;
        else if (advance) lfsr_q <= lfsr_nxt;
    end

    assign state_o = lfsr_q;
endmodule

// File: rtl/adcpk_lanes.sv
module adcpk_lanes #(
    parameter int DW  = 8,
    parameter int SPW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              wrap,
    input  logic [DW-1:0]     din,
    output logic [SPW*DW-1:0] hold_o,
    output logic              tog_o
);
    localparam int WORD_W = SPW * DW;

    logic [WORD_W-1:0] word_nxt;
    logic [WORD_W-1:0] hold_q;
    logic              tog_q;

    for (genvar b = 0; b < DW; b++) begin : g_lane
        logic [SPW-1:0] sr_q;
        logic [SPW-1:0] sr_nxt;

        assign sr_nxt = {din[b], sr_q[SPW-1:1]};

        always_ff @(posedge clk) begin
            if (rst)           sr_q <= '0;
            else if (shift_en) sr_q <= sr_nxt;
        end

        for (genvar s = 0; s < SPW; s++) begin : g_slot
            assign word_nxt[s*DW + b] = sr_nxt[s];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            tog_q  <= 1'b0;
        end else if (shift_en && wrap) begin
            hold_q <= word_nxt;
            tog_q  <= ~tog_q;
        end
    end

    assign hold_o = hold_q;
    assign tog_o  = tog_q;
endmodule

// File: rtl/adcpk_handoff.sv
module adcpk_handoff #(
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tog_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              wr_en_o,
    output logic [WORD_W-1:0] wr_data_o
);
    logic              sync1_q, sync2_q, seen_q;
    logic              flip;
    logic              en_q;
    logic [WORD_W-1:0] data_q;

    assign flip = sync2_q ^ seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            seen_q  <= 1'b0;
            en_q    <= 1'b0;
            data_q  <= '0;
        end else begin
            sync1_q <= tog_i;
            sync2_q <= sync1_q;
            seen_q  <= sync2_q;
            en_q    <= flip;
            if (flip) data_q <= word_i;
        end
    end

    assign wr_en_o   = en_q;
    assign wr_data_o = data_q;
endmodule

// File: rtl/adc_sample_packer.sv
module adc_sample_packer #(
    parameter int ADC_WIDTH        = 8,
    parameter int SAMPLES_PER_WORD = 8,
    parameter int LFSR_WIDTH       = 4
) (
    input  logic                                  clk_fast,
    input  logic                                  rst_fast,
    input  logic                                  clk_slow,
    input  logic                                  rst_slow,
    input  logic                                  edge_sel,
    input  logic [ADC_WIDTH-1:0]                  adc_data_i,
    output logic                                  adc_clk_o,
    output logic                                  wr_en_o,
    output logic [SAMPLES_PER_WORD*ADC_WIDTH-1:0] wr_data_o
);
    import adcpk_pkg::*;

    localparam int WORD_W = SAMPLES_PER_WORD * ADC_WIDTH;

    pack_state_e           state_q, state_nxt;
    logic                  shift_en;
    logic                  wrap;
    logic [LFSR_WIDTH-1:0] lfsr_q;
    logic [ADC_WIDTH-1:0]  sample;
    logic [WORD_W-1:0]     hold_w;
    logic                  tog_q;

    assign adc_clk_o = ~clk_fast;

    always_ff @(posedge clk_fast) begin
        if (rst_fast) state_q <= ST_WARM;
        else          state_q <= state_nxt;
    end

    always_comb begin
        state_nxt = state_q;
        shift_en  = 1'b0;
        unique case (state_q)
            ST_WARM: state_nxt = ST_PACK;
            ST_PACK: shift_en  = 1'b1;
        endcase
    end

    adcpk_capture #(.DW(ADC_WIDTH)) u_cap (
        .clk      (clk_fast),
        .rst      (rst_fast),
        .edge_sel (edge_sel),
        .din      (adc_data_i),
        .dout     (sample)
    );

    adcpk_lfsr_count #(.W(LFSR_WIDTH), .SPW(SAMPLES_PER_WORD)) u_cnt (
        .clk     (clk_fast),
        .rst     (rst_fast),
        .advance (shift_en),
        .state_o (lfsr_q),
        .wrap_o  (wrap)
    );

    adcpk_lanes #(.DW(ADC_WIDTH), .SPW(SAMPLES_PER_WORD)) u_lanes (
        .clk      (clk_fast),
        .rst      (rst_fast),
        .shift_en (shift_en),
        .wrap     (wrap),
        .din      (sample),
        .hold_o   (hold_w),
        .tog_o    (tog_q)
    );

    adcpk_handoff #(.WORD_W(WORD_W)) u_xfer (
        .clk       (clk_slow),
        .rst       (rst_slow),
        .tog_i     (tog_q),
        .word_i    (hold_w),
        .wr_en_o   (wr_en_o),
        .wr_data_o (wr_data_o)
    );
endmodule

// File: rtl/adc_sample_packer_chk.sv
module adc_sample_packer_chk #(
    parameter int ADC_WIDTH        = 8,
    parameter int SAMPLES_PER_WORD = 8,
    parameter int LFSR_WIDTH       = 4
) (
    input logic                                  clk_fast,
    input logic                                  rst_fast,
    input logic                                  clk_slow,
    input logic                                  rst_slow,
    input adcpk_pkg::pack_state_e                state_q,
    input logic [LFSR_WIDTH-1:0]                 lfsr_q,
    input logic                                  tog_q,
    input logic                                  wr_en_o,
    input logic [SAMPLES_PER_WORD*ADC_WIDTH-1:0] wr_data_o
);
    import adcpk_pkg::*;

    localparam logic [LFSR_WIDTH-1:0] SEED = LFSR_WIDTH'(1);
    localparam logic [LFSR_WIDTH-1:0] TERM =
        LFSR_WIDTH'(lfsr_after(16'd1, LFSR_WIDTH, SAMPLES_PER_WORD - 1));

    // R4
    lfsr_nonzero_chk: assert property (@(posedge clk_fast) disable iff (rst_fast)
        lfsr_q != '0);

    // R4
    lfsr_reload_chk: assert property (@(posedge clk_fast) disable iff (rst_fast)
        (state_q == ST_PACK && lfsr_q == TERM) |=> (lfsr_q == SEED));

    // R5
    toggle_at_term_chk: assert property (@(posedge clk_fast) disable iff (rst_fast)
        (tog_q != $past(tog_q)) |-> ($past(lfsr_q) == TERM && $past(state_q) == ST_PACK));

    // R6
    warm_quiet_chk: assert property (@(posedge clk_fast) disable iff (rst_fast)
        (state_q == ST_WARM) |=> $stable(tog_q));

    // R7
    single_pulse_chk: assert property (@(posedge clk_slow) disable iff (rst_slow)
        wr_en_o |=> !wr_en_o);

    // R7
    data_hold_chk: assert property (@(posedge clk_slow) disable iff (rst_slow)
        !$stable(wr_data_o) |-> wr_en_o);
endmodule

bind adc_sample_packer adc_sample_packer_chk #(
    .ADC_WIDTH        (ADC_WIDTH),
    .SAMPLES_PER_WORD (SAMPLES_PER_WORD),
    .LFSR_WIDTH       (LFSR_WIDTH)
) u_chk (
    .clk_fast  (clk_fast),
    .rst_fast  (rst_fast),
    .clk_slow  (clk_slow),
    .rst_slow  (rst_slow),
    .state_q   (state_q),
    .lfsr_q    (lfsr_q),
    .tog_q     (tog_q),
    .wr_en_o   (wr_en_o),
    .wr_data_o (wr_data_o)
);

// File: tb/tb_adc_sample_packer.sv
`timescale 1ns/1ps
module tb_adc_sample_packer;
    localparam int DW     = 8;
    localparam int SPW    = 8;
    localparam int LW     = 4;
    localparam int WORD_W = DW * SPW;
    localparam real FAST_NS = 4.0;

    logic              clk_fast = 1'b0;
    logic              clk_slow = 1'b0;
    logic              rst_fast = 1'b1;
    logic              rst_slow = 1'b1;
    logic              edge_sel = 1'b0;
    logic [DW-1:0]     adc_data = '0;
    logic              adc_clk_o;
    logic              wr_en_o;
    logic [WORD_W-1:0] wr_data_o;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;
    realtime t_rel;

    adc_sample_packer #(.ADC_WIDTH(DW), .SAMPLES_PER_WORD(SPW), .LFSR_WIDTH(LW)) dut (
        .clk_fast   (clk_fast),
        .rst_fast   (rst_fast),
        .clk_slow   (clk_slow),
        .rst_slow   (rst_slow),
        .edge_sel   (edge_sel),
        .adc_data_i (adc_data),
        .adc_clk_o  (adc_clk_o),
        .wr_en_o    (wr_en_o),
        .wr_data_o  (wr_data_o)
    );

    initial forever #2 clk_fast = ~clk_fast;
    initial begin
        #1;
        forever #4 clk_slow = ~clk_slow;
    end

    // ADC model: next ramp value 1 ns after each rising edge of its sample clock
    initial begin
        forever begin
            @(posedge adc_clk_o);
            #1;
            adc_data = adc_data + 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] slot(input logic [WORD_W-1:0] w, input int s);
        return w[s*DW +: DW];
    endfunction

    task automatic do_reset(input logic sel);
        @(negedge clk_fast);
        rst_fast = 1'b1;
        rst_slow = 1'b1;
        edge_sel = sel;
        repeat (6) @(negedge clk_fast);
        // R6: outputs cleared while reset is held
        chk(wr_en_o == 1'b0, "R6", "wr_en_o in reset", WORD_W'(wr_en_o), '0);
        chk(wr_data_o == '0, "R6", "wr_data_o in reset", wr_data_o, '0);
        rst_fast = 1'b0;
        rst_slow = 1'b0;
        t_rel = $realtime;
    endtask

    task automatic wait_write(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk_slow);
            if (wr_en_o) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic test_clock_out();
        for (int i = 0; i < 4; i++) begin
            @(posedge clk_fast);
            #1;
            chk(adc_clk_o == 1'b0, "R3", "adc_clk_o while clk_fast high", WORD_W'(adc_clk_o), '0);
            @(negedge clk_fast);
            #1;
            chk(adc_clk_o == 1'b1, "R3", "adc_clk_o while clk_fast low", WORD_W'(adc_clk_o), 1);
        end
    endtask

    task automatic run_words(input logic sel, input int nwords, input string tag);
        logic [DW-1:0]     last;
        logic [WORD_W-1:0] held;
        realtime           t_prev, t_now;
        bit                seen;
        do_reset(sel);
        last   = '0;
        t_prev = 0;
        for (int w = 0; w < nwords; w++) begin
            wait_write(seen);
            if (!seen) begin
                chk(1'b0, "R5", {tag, " write never arrived"}, '0, 1);
                return;
            end
            t_now = $realtime;
            if (w == 0) begin
                // R6: first word needs SPW samples after reset release
                chk(t_now - t_rel >= SPW * FAST_NS, "R6", {tag, " first write too early"},
                    WORD_W'(int'(t_now - t_rel)), WORD_W'(SPW * 4));
                chk(t_now - t_rel < (SPW + 12) * FAST_NS, "R6", {tag, " first write too late"},
                    WORD_W'(int'(t_now - t_rel)), WORD_W'((SPW + 12) * 4));
            end else begin
                // R5: one word every SPW fast periods
                chk(t_now - t_prev == SPW * FAST_NS, "R5", {tag, " write spacing"},
                    WORD_W'(int'(t_now - t_prev)), WORD_W'(SPW * 4));
                // R2 / R8: no gap or repeat across words
                chk(slot(wr_data_o, 0) == DW'(last + 1'b1), "R2", {tag, " R8 word continuity"},
                    WORD_W'(slot(wr_data_o, 0)), WORD_W'(DW'(last + 1'b1)));
            end
            // R1: slots hold consecutive samples, oldest in slot 0
            for (int s = 1; s < SPW; s++) begin
                chk(slot(wr_data_o, s) == DW'(slot(wr_data_o, 0) + s), "R1", {tag, " slot order"},
                    WORD_W'(slot(wr_data_o, s)), WORD_W'(DW'(slot(wr_data_o, 0) + s)));
            end
            last   = slot(wr_data_o, SPW - 1);
            held   = wr_data_o;
            t_prev = t_now;
            // R7: pulse lasts one cycle and data holds after it
            @(negedge clk_slow);
            chk(wr_en_o == 1'b0, "R7", {tag, " enable one cycle"}, WORD_W'(wr_en_o), '0);
            chk(wr_data_o == held, "R7", {tag, " data held"}, wr_data_o, held);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        test_clock_out();
        run_words(1'b0, 12, "rise");
        run_words(1'b1, 12, "fall");
        // reset lands mid-word of the previous run; packing restarts cleanly
        repeat (3) @(negedge clk_fast);
        run_words(1'b0, 6, "rise-again");
        finish_run();
    end
endmodule